// File: doc/BRIEF.md
# Thermal Trip and Throttle Arbiter

This block decides, every clock cycle, whether the cores of a multi-core die must run throttled. Each core supplies a signed temperature code. The code is measured relative to the throttle trip point, so zero means the die has reached the activation temperature and positive codes mean it is hotter. When any core reaches the trip point, the block pulls a shared open-drain throttle pin low. The pin stays low through a fixed exit hysteresis window after the die cools, so it does not chatter around the trip point.

The shared throttle flag raises when any of three things holds: a thermal trip while the enable bit is set, an external device holding the pin low while the pin is configured as bidirectional, or the force input. An edge detector produces one-cycle interrupt pulses when the flag rises and when it falls. A second, higher tier latches a catastrophic-shutdown flag that only a reset clears. A fan-reduce hint compares the hottest core against a control threshold. The trip point is fixed at code zero, and the shutdown offset and hysteresis length are parameters.

Top module: `thermal_throttle_arbiter`

## Requirements
- R1: While reset is applied, the pin is released (pin_drv_n = 1), and throttle_active, shutdown, fan_reduce, irq_on and irq_off are all 0.
- R2: core_temp packs one signed two's-complement code per core, core c in bits [8c+7:8c] (TEMP_W = 8). If any core code is >= 0 at a clock edge, pin_drv_n is 0 after that edge, whatever tm_enable holds.
- R3: With tm_enable = 1, a thermal trip sets throttle_active one edge after the pin is driven. With tm_enable = 0, a thermal trip drives the pin but leaves throttle_active at 0.
- R4: Once every core code is below 0, the pin stays driven for exactly HYST_CYCLES further edges (default 16) and is released on the last of them. Any edge that sees a code >= 0 inside that window restarts the full window.
- R5: With pin_mode = 1 (bidirectional), pin_in_n = 0 while the block is not driving the pin sets throttle_active at the next edge. The flag holds until pin_in_n returns to 1. The flag never drops when the block releases the pin while the external device still holds it low.
- R6: With pin_mode = 0 (output only), pin_in_n has no effect on throttle_active.
- R7: force_thr = 1 at an edge makes throttle_active 1 after that edge.
- R8: If any core code is >= SHUT_OFFSET (default 22) at an edge, shutdown is 1 after it. Shutdown then stays 1 until reset, even after the die cools. A code of SHUT_OFFSET-1 does not set it.
- R9: After each edge, fan_reduce is 1 exactly when the hottest core code is strictly below the signed ctrl_thresh. When the code equals the threshold, fan_reduce is 0.
- R10: irq_on is a one-cycle pulse at the edge where throttle_active goes 0 to 1, and irq_off is a one-cycle pulse at the edge where it goes 1 to 0. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tm_enable | input | 1 | Lets a thermal trip raise the throttle flag |
| pin_mode | input | 1 | 0 = pin output only, 1 = bidirectional |
| pin_in_n | input | 1 | Sensed level of the open-drain throttle pin, active low |
| force_thr | input | 1 | Force throttling |
| ctrl_thresh | input | TEMP_W | Signed fan control threshold |
| core_temp | input | NUM_CORES*TEMP_W | Packed signed per-core codes relative to trip |
| pin_drv_n | output | 1 | Open-drain pull-down request, 0 = drive low |
| throttle_active | output | 1 | Shared throttle flag for all cores |
| shutdown | output | 1 | Latched catastrophic-overtemperature flag |
| fan_reduce | output | 1 | Fan may slow down |
| irq_on | output | 1 | Pulse when throttling starts |
| irq_off | output | 1 | Pulse when throttling ends |

## Verification
The hardest situation to bring about is the handover on the shared pin. The internal trip has to expire while an external device is still holding the pin low. If it does, the flag must stay up with no gap and no falling pulse. The stimulus first heats a core, then asserts the external pull-down in the same cycle the core cools, and counts the hysteresis window down so the block's own release lands under the held pin. A second awkward case is a short reheat in the middle of the hysteresis window. The bench reaches it by counting edges exactly, and it checks that the release moves out by a full window.

// File: rtl/thm_pkg.sv
`timescale 1ns/1ps
package thm_pkg;
   typedef enum logic {
      PIN_OUT_ONLY = 1'b0,
      PIN_BIDIR    = 1'b1
   } pin_mode_e;
endpackage

// File: rtl/thm_temp_reduce.sv
`timescale 1ns/1ps
module thm_temp_reduce #(
   parameter int NUM_CORES = 2,
   parameter int TEMP_W    = 8
) (
   input  logic [NUM_CORES*TEMP_W-1:0] core_temp,
   output logic signed [TEMP_W-1:0]    hottest
);
   generate
      if (NUM_CORES == 1) begin : g_single
         assign hottest = $signed(core_temp);
      end else begin : g_multi
         always_comb begin
            hottest = $signed(core_temp[TEMP_W-1:0]);
            for (int c = 1; c < NUM_CORES; c++) begin
               if ($signed(core_temp[c*TEMP_W +: TEMP_W]) > hottest)
                  hottest = $signed(core_temp[c*TEMP_W +: TEMP_W]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/thm_hyst_timer.sv
`timescale 1ns/1ps
module thm_hyst_timer #(
   parameter int HYST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot,
   output logic trip
);
   generate
      if (HYST_CYCLES == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trip <= 1'b0;
            else        trip <= hot;
         end
      end else begin : g_window
         localparam int CNT_W = $clog2(HYST_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trip  <= 1'b0;
               cnt_q <= '0;
            end else if (hot) begin
               trip  <= 1'b1;
               cnt_q <= CNT_W'(HYST_CYCLES);
            end else if (trip) begin
               if (cnt_q == CNT_W'(1)) trip <= 1'b0;
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end

         AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (trip && !hot && cnt_q != CNT_W'(1)) |=> trip); // R4
      end
   endgenerate

   AST_HOT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      hot |=> trip); // R2
endmodule

// File: rtl/thm_edge_pulse.sv
`timescale 1ns/1ps
module thm_edge_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic level_d,
   output logic level_q,
   output logic rise,
   output logic fall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         rise    <= 1'b0;
         fall    <= 1'b0;
      end else begin
         level_q <= level_d;
         rise    <= level_d & ~level_q;
         fall    <= ~level_d & level_q;
      end
   end

   AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R10
   AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (level_q && !$past(level_q))); // R10
   AST_FALL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> (!level_q && $past(level_q))); // R10
endmodule

// File: rtl/thermal_throttle_arbiter.sv
`timescale 1ns/1ps
module thermal_throttle_arbiter
   import thm_pkg::*;
#(
   parameter int NUM_CORES   = 2,
   parameter int TEMP_W      = 8,
   parameter int SHUT_OFFSET = 22,
   parameter int HYST_CYCLES = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tm_enable,
   input  logic                        pin_mode,
   input  logic                        pin_in_n,
   input  logic                        force_thr,
   input  logic signed [TEMP_W-1:0]    ctrl_thresh,
   input  logic [NUM_CORES*TEMP_W-1:0] core_temp,
   output logic                        pin_drv_n,
   output logic                        throttle_active,
   output logic                        shutdown,
   output logic                        fan_reduce,
   output logic                        irq_on,
   output logic                        irq_off
);
   localparam logic signed [TEMP_W-1:0] SHUT_CODE = (TEMP_W)'(SHUT_OFFSET);

   generate
      if (TEMP_W < 4) begin : g_bad_width
         $error("TEMP_W must be at least 4");
      end
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
      if (SHUT_OFFSET < 1 || SHUT_OFFSET >= (1 << (TEMP_W - 1))) begin : g_bad_offset
         $error("SHUT_OFFSET must be positive and fit the signed code");
      end
      if (HYST_CYCLES < 0) begin : g_bad_hyst
         $error("HYST_CYCLES must not be negative");
      end
   endgenerate

   logic signed [TEMP_W-1:0] hottest;
   logic hot_now, trip, ext_now, act_d;
   logic shut_q, fan_q;

   thm_temp_reduce #(.NUM_CORES(NUM_CORES), .TEMP_W(TEMP_W)) u_reduce (
      .core_temp (core_temp),
      .hottest   (hottest)
   );

   assign hot_now = ~hottest[TEMP_W-1];

   thm_hyst_timer #(.HYST_CYCLES(HYST_CYCLES)) u_hyst (
      .clk   (clk),
      .rst_n (rst_n),
      .hot   (hot_now),
      .trip  (trip)
   );

   assign pin_drv_n = ~trip;

   // external pull-down is only visible while this block leaves the pin released
   assign ext_now = (pin_mode_e'(pin_mode) == PIN_BIDIR) & ~pin_in_n & pin_drv_n;
   assign act_d   = (tm_enable & trip) | ext_now | force_thr;

   thm_edge_pulse u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_d (act_d),
      .level_q (throttle_active),
      .rise    (irq_on),
      .fall    (irq_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shut_q <= 1'b0;
         fan_q  <= 1'b0;
      end else begin
         if (hottest >= SHUT_CODE) shut_q <= 1'b1;
         fan_q <= (hottest < ctrl_thresh);
      end
   end

   assign shutdown   = shut_q;
   assign fan_reduce = fan_q;

   AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown); // R8
   AST_FORCE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      force_thr |=> throttle_active); // R7
   AST_EXT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode && !pin_in_n && pin_drv_n) |=> throttle_active); // R5
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tm_enable && !force_thr && !pin_mode) |=> !throttle_active); // R3
endmodule

// File: tb/tb_thermal_throttle_arbiter.sv
`timescale 1ns/1ps
module tb_thermal_throttle_arbiter;
   localparam int H = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tm_enable = 1'b1, pin_mode = 1'b1, force_thr = 1'b0, ext_n = 1'b1;
   logic signed [7:0] ctrl_thresh = -8'sd10;
   logic signed [7:0] t0 = -8'sd40, t1 = -8'sd40;
   logic pin_in_n, pin_drv_n, throttle_active, shutdown, fan_reduce, irq_on, irq_off;

   logic en_nx = 1'b1, mode_nx = 1'b1, frc_nx = 1'b0, extn_nx = 1'b1;
   logic signed [7:0] thr_nx = -8'sd10;

   int errors = 0, checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   // wired-AND of the open-drain pin: this block and an external device
   assign pin_in_n = pin_drv_n & ext_n;

   thermal_throttle_arbiter #(.NUM_CORES(2), .TEMP_W(8), .SHUT_OFFSET(22), .HYST_CYCLES(H)) dut (
      .clk(clk), .rst_n(rst_n), .tm_enable(tm_enable), .pin_mode(pin_mode),
      .pin_in_n(pin_in_n), .force_thr(force_thr), .ctrl_thresh(ctrl_thresh),
      .core_temp({t1, t0}), .pin_drv_n(pin_drv_n), .throttle_active(throttle_active),
      .shutdown(shutdown), .fan_reduce(fan_reduce), .irq_on(irq_on), .irq_off(irq_off)
   );

   // bit order: {off, on, fan, shut, act, pin}
   localparam logic [5:0] M_PIN = 6'b000001, M_ACT = 6'b000010, M_SHUT = 6'b000100,
                          M_FAN = 6'b001000, M_IRQ = 6'b110000;
   localparam logic [5:0] M_THR = M_PIN | M_ACT | M_IRQ;
   localparam logic [5:0] M_ALL = 6'b111111;

   typedef struct { logic [5:0] m; logic [5:0] e; string r; } item_t;
   item_t sb[$];

   function automatic logic [5:0] ex(input logic pin, input logic act, input logic sh,
                                     input logic fan, input logic on, input logic off);
      return {off, on, fan, sh, act, pin};
   endfunction

   function automatic logic [5:0] observed();
      return {irq_off, irq_on, fan_reduce, shutdown, throttle_active, ~pin_drv_n};
   endfunction

   // driver: apply staged inputs at a falling edge and queue the outputs expected after the next rising edge
   task automatic tick(input logic signed [7:0] a, input logic signed [7:0] b,
                       input logic [5:0] m, input logic [5:0] e, input string r);
      item_t it;
      @(negedge clk);
      t0 = a; t1 = b;
      tm_enable = en_nx; pin_mode = mode_nx; force_thr = frc_nx;
      ext_n = extn_nx; ctrl_thresh = thr_nx;
      it.m = m; it.e = e; it.r = r;
      sb.push_back(it);
   endtask

   // monitor: pop one expectation per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.m != 6'b0) begin
               checks++;
               if ((observed() & it.m) != (it.e & it.m)) begin
                  errors++;
                  $display("FAIL %s: got %b expected %b (mask %b, order off,on,fan,shut,act,pin)",
                           it.r, observed() & it.m, it.e & it.m, it.m);
               end
            end
         end
      end
   end

   task automatic direct_check(input logic [5:0] e, input string r);
      checks++;
      if (observed() != e) begin
         errors++;
         $display("FAIL %s: got %b expected %b", r, observed(), e);
      end
   endtask

   initial begin
      #(8 * 3000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      direct_check(ex(0,0,0,0,0,0), "R1 reset state");
      rst_n = 1'b1;

      // R9 cold die: fan may slow; nothing active
      tick(-40, -40, M_ALL, ex(0,0,0,1,0,0), "R1 R9 idle after reset");
      // R2 code 0 on core 1 is the trip point
      tick(-40, 0, M_ALL, ex(1,0,0,0,0,0), "R2 trip drives pin");
      tick(-40, 0, M_THR, ex(1,1,0,0,1,0), "R3 R10 throttle follows pin, irq_on");
      tick(-40, 0, M_THR, ex(1,1,0,0,0,0), "R10 irq_on single cycle");
      // R4 restart: cool 5, reheat 1, then a full window
      for (int k = 0; k < 5; k++) tick(-5, -5, M_THR, ex(1,1,0,0,0,0), "R4 hold in window");
      tick(3, -5, M_THR, ex(1,1,0,0,0,0), "R4 reheat in window");
      for (int k = 1; k < H; k++) tick(-5, -5, M_THR, ex(1,1,0,0,0,0), "R4 restarted window holds");
      tick(-5, -5, M_THR, ex(0,1,0,0,0,0), "R4 pin released after window");
      tick(-5, -5, M_THR, ex(0,0,0,0,0,1), "R10 irq_off on fall");
      tick(-5, -5, M_THR, ex(0,0,0,0,0,0), "R10 irq_off single cycle");

      // R3 disabled: pin still driven, no throttle
      en_nx = 1'b0;
      tick(4, -40, M_THR, ex(1,0,0,0,0,0), "R3 R2 disabled trip drives pin only");
      tick(4, -40, M_THR, ex(1,0,0,0,0,0), "R3 disabled no throttle");
      for (int k = 1; k < H; k++) tick(-40, -40, M_THR, ex(1,0,0,0,0,0), "R3 R4 disabled window");
      tick(-40, -40, M_THR, ex(0,0,0,0,0,0), "R4 disabled release");
      en_nx = 1'b1;
      tick(-40, -40, M_THR, ex(0,0,0,0,0,0), "R3 re-enable idle");

      // R5 external pull-down in bidirectional mode
      extn_nx = 1'b0;
      tick(-40, -40, M_THR, ex(0,1,0,0,1,0), "R5 external assert");
      tick(-40, -40, M_THR, ex(0,1,0,0,0,0), "R5 external hold");
      extn_nx = 1'b1;
      tick(-40, -40, M_THR, ex(0,0,0,0,0,1), "R5 external release");

      // R6 output-only ignores the pin
      mode_nx = 1'b0; extn_nx = 1'b0;
      for (int k = 0; k < 3; k++) tick(-40, -40, M_THR, ex(0,0,0,0,0,0), "R6 pin input ignored");
      mode_nx = 1'b1; extn_nx = 1'b1;
      tick(-40, -40, M_THR, ex(0,0,0,0,0,0), "R6 back to idle");

      // R7 force input
      frc_nx = 1'b1;
      tick(-40, -40, M_THR, ex(0,1,0,0,1,0), "R7 force throttles");
      frc_nx = 1'b0;
      tick(-40, -40, M_THR, ex(0,0,0,0,0,1), "R7 force released");

      // R5 handover: own trip expires under an external hold
      tick(0, -40, M_THR, ex(1,0,0,0,0,0), "R2 handover trip");
      tick(0, -40, M_THR, ex(1,1,0,0,1,0), "R3 handover throttle");
      extn_nx = 1'b0;
      for (int k = 1; k < H; k++) tick(-40, -40, M_THR, ex(1,1,0,0,0,0), "R5 handover window");
      tick(-40, -40, M_THR, ex(0,1,0,0,0,0), "R5 own release under hold");
      tick(-40, -40, M_THR, ex(0,1,0,0,0,0), "R5 no gap, no irq_off");
      extn_nx = 1'b1;
      tick(-40, -40, M_THR, ex(0,0,0,0,0,1), "R5 R10 external release after handover");

      // R9 threshold boundary
      thr_nx = -8'sd5;
      tick(-5, -20, M_FAN, ex(0,0,0,0,0,0), "R9 equal to threshold");
      tick(-6, -20, M_FAN, ex(0,0,0,1,0,0), "R9 below threshold");
      tick(-20, -4, M_FAN, ex(0,0,0,0,0,0), "R9 hottest core decides");

      // R8 shutdown tier
      tick(21, -40, M_SHUT, ex(0,0,0,0,0,0), "R8 one below offset");
      tick(-40, 22, M_SHUT, ex(0,0,1,0,0,0), "R8 at offset");
      for (int k = 0; k < 3; k++) tick(-40, -40, M_SHUT, ex(0,0,1,0,0,0), "R8 latched after cooling");

      repeat (3) @(posedge clk);
      #3;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule